// File: doc/BRIEF.md
# Serial-Loop Character Screen Store

This block keeps a whole text screen of 6-bit character codes in a set of recirculating serial loops instead of addressable RAM. A raster sequencer moves the loops in step with the scan. A full frame has 24 text rows of 40 cells, and each row spans 8 scan lines. The main loop holds 1024 positions. It advances one position per clock on the first scan line of every row, and again through 64 positions in a blanking stretch at the end of the frame. A 40-position row loop captures each row as it goes past, so that the same codes can be shown again on the remaining scan lines of that row.

A host writes text through a 7-bit character port and a strobe. The block cannot reach an arbitrary cell, so it holds the character until the moving loop brings the cursor cell past. At that moment the low six bits take the place of the recirculated code, the cursor steps forward, and the ready flag rises again. The carriage-return value moves the cursor to the start of the next row and writes nothing. A clear request fills every position with the space code during one complete pass of the loop. For every active cell the block gives a glyph-ROM address and the scan line within the row. The depth must exceed rows times columns.

Top module: `textscreen_store`

## Requirements
- R1: A synchronous reset (rst high) sets host_ready to 1, drops any held character, homes the cursor to row 0 column 0, and restarts the raster at row 0, scan line 0, column 0 with cell_active high.
- R2: One frame is ROWS×LINES×COLS active cells followed by DEPTH−ROWS×COLS inactive cells (cell_active low, glyph_addr 0). Columns 0..COLS−1 run within a line, and lines 0..LINES−1 run within a row.
- R3: A strobe while host_ready is 1 latches the full 7-bit host_char, and host_ready reads 0 from the next cycle. A strobe while host_ready is 0 is ignored and leaves the held character unchanged.
- R4: When the loop position for row r, column c (position r×COLS+c, passed on scan line 0 of row r) equals the cursor and a non-return character is held, the low six bits of that character replace the stored code. On that same cycle glyph_addr shows the new code.
- R5: host_ready returns to 1 on the clock edge that ends the insert cycle, and it rises at no other time.
- R6: After an insert the cursor moves one column right. After the last column it moves to column 0 of the next row, and after the last row it returns to row 0.
- R7: The held value 7'h0D stores nothing. The cell keeps its old code, and the cursor moves to column 0 of the next row, wrapping from the last row to row 0. Values whose low six bits are 6'h0D but whose bit 6 is 1 are stored as code 6'h0D.
- R8: On scan lines 1..LINES−1 of a row, each cell shows the code that the same column showed on line 0 of that row. scan_line shows the current line.
- R9: A clear request sets a pending flag. From the next frame start, every one of the DEPTH positions is written with 6'h20 during exactly one frame, and no host insert takes place during that frame.
- R10: Positions that are neither written nor cleared keep their code from frame to frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock; one cell per cycle |
| rst | input | 1 | Synchronous reset, active high |
| host_char | input | 7 | Character presented by the host |
| host_strobe | input | 1 | One-cycle request to take host_char |
| host_ready | output | 1 | High when no character is waiting to be stored |
| clear_req | input | 1 | Request to fill the screen with spaces |
| cell_active | output | 1 | High for displayed cells, low during blanking |
| scan_line | output | 3 | Scan line within the current text row |
| glyph_addr | output | 6 | Character code to address the glyph ROM |

## Verification
The assertions assume that the host strobes for a single cycle and uses the ready flag as its only gate. They also assume that the clear request is an ordinary synchronous pulse, which may coincide with a strobe. The stimulus sends each character only after the ready flag is seen high. On purpose, it also adds strobes while the flag is low, and a strobe in the same cycle as a clear request, so that the ignore and hold-off rules are tested. The bench shrinks the screen through parameters to keep the loop short. It leaves its reference unknown until the first clear, and it compares the glyph only where the stored content is known.

// File: rtl/textscreen_pkg.sv
package textscreen_pkg;

    localparam int HOST_W = 7;
    localparam int CODE_W = 6;

    localparam logic [HOST_W-1:0] RETURN_CHAR = 7'h0D;
    localparam logic [CODE_W-1:0] BLANK_CODE  = 6'h20;

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/raster_seq.sv
module raster_seq
    import textscreen_pkg::*;
#(
    parameter int COLS  = 40,
    parameter int LINES = 8,
    parameter int ROWS  = 24,
    parameter int DEPTH = 1024
) (
    input  logic                             clk,
    input  logic                             rst,
    output logic                             active,
    output logic                             shift_en,
    output logic                             frame_end,
    output logic [safe_clog2(COLS)-1:0]      col,
    output logic [safe_clog2(LINES)-1:0]     line,
    output logic [safe_clog2(ROWS)-1:0]      row,
    output logic [safe_clog2(DEPTH)-1:0]     slot
);
    localparam int COL_W  = safe_clog2(COLS);
    localparam int LINE_W = safe_clog2(LINES);
    localparam int ROW_W  = safe_clog2(ROWS);
    localparam int SLOT_W = safe_clog2(DEPTH);

    typedef struct packed {
        logic              blank;
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
        logic [ROW_W-1:0]  row;
        logic [SLOT_W-1:0] slot;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (scan_q.blank) begin
            if (scan_q.slot == SLOT_W'(DEPTH - 1)) begin
                scan_d = '0;
            end else begin
                scan_d.slot = scan_q.slot + SLOT_W'(1);
            end
        end else begin
            if (scan_q.line == '0) begin
                scan_d.slot = scan_q.slot + SLOT_W'(1);
            end
            if (scan_q.col == COL_W'(COLS - 1)) begin
                scan_d.col = '0;
                if (scan_q.line == LINE_W'(LINES - 1)) begin
                    scan_d.line = '0;
                    if (scan_q.row == ROW_W'(ROWS - 1)) begin
                        scan_d.row   = '0;
                        scan_d.blank = 1'b1;
                    end else begin
                        scan_d.row = scan_q.row + ROW_W'(1);
                    end
                end else begin
                    scan_d.line = scan_q.line + LINE_W'(1);
                end
            end else begin
                scan_d.col = scan_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign active    = !scan_q.blank;
    assign shift_en  = scan_q.blank || (scan_q.line == '0);
    assign frame_end = scan_q.blank && (scan_q.slot == SLOT_W'(DEPTH - 1));
    assign col       = scan_q.col;
    assign line      = scan_q.line;
    assign row       = scan_q.row;
    assign slot      = scan_q.slot;

endmodule

// File: rtl/store_plane.sv
module store_plane #(
    parameter int DEPTH  = 1024,
    parameter int COLS   = 40,
    parameter int SLOT_W = 10
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic              row_en,
    input  logic              row_load,
    input  logic              ins_bit,
    output logic              store_bit,
    output logic              row_bit
);
    logic [DEPTH-1:0] loop_q;
    logic [COLS-1:0]  row_q;
    logic             row_in;

    assign store_bit = loop_q[slot];
    assign row_bit   = row_q[COLS-1];
    assign row_in    = row_load ? ins_bit : row_q[COLS-1];

    always_ff @(posedge clk) begin
        if (shift_en) begin
            loop_q[slot] <= ins_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (row_en) begin
            row_q <= {row_q[COLS-2:0], row_in};
        end
    end

endmodule

// File: rtl/textscreen_store.sv
module textscreen_store
    import textscreen_pkg::*;
#(
    parameter int COLS  = 40,
    parameter int LINES = 8,
    parameter int ROWS  = 24,
    parameter int DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [HOST_W-1:0]            host_char,
    input  logic                         host_strobe,
    output logic                         host_ready,
    input  logic                         clear_req,
    output logic                         cell_active,
    output logic [safe_clog2(LINES)-1:0] scan_line,
    output logic [CODE_W-1:0]            glyph_addr
);
    localparam int COL_W  = safe_clog2(COLS);
    localparam int LINE_W = safe_clog2(LINES);
    localparam int ROW_W  = safe_clog2(ROWS);
    localparam int SLOT_W = safe_clog2(DEPTH);

    typedef struct packed {
        logic [COL_W-1:0]  cur_col;
        logic [ROW_W-1:0]  cur_row;
        logic              pending;
        logic [HOST_W-1:0] code;
        logic              ready;
        logic              clr_pend;
        logic              clr_run;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              active, shift_en, frame_end;
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
    logic [ROW_W-1:0]  row;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] cur_slot;
    logic [CODE_W-1:0] store_out, row_out, ins;
    logic              hit, is_return, clr_run;
    logic [HOST_W-1:0] held_code;

    raster_seq #(
        .COLS (COLS),
        .LINES(LINES),
        .ROWS (ROWS),
        .DEPTH(DEPTH)
    ) u_raster (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .shift_en (shift_en),
        .frame_end(frame_end),
        .col      (col),
        .line     (line),
        .row      (row),
        .slot     (slot)
    );

    for (genvar b = 0; b < CODE_W; b++) begin : g_plane
        store_plane #(
            .DEPTH (DEPTH),
            .COLS  (COLS),
            .SLOT_W(SLOT_W)
        ) u_plane (
            .clk      (clk),
            .shift_en (shift_en),
            .slot     (slot),
            .row_en   (active),
            .row_load (line == '0),
            .ins_bit  (ins[b]),
            .store_bit(store_out[b]),
            .row_bit  (row_out[b])
        );
    end

    assign cur_slot  = SLOT_W'(int'(ctl_q.cur_row) * COLS) + SLOT_W'(ctl_q.cur_col);
    assign held_code = ctl_q.code;
    assign clr_run   = ctl_q.clr_run;
    assign is_return = (ctl_q.code == RETURN_CHAR);
    assign hit       = shift_en && !ctl_q.clr_run && ctl_q.pending && (slot == cur_slot);

    always_comb begin
        if (ctl_q.clr_run) begin
            ins = BLANK_CODE;
        end else if (hit && !is_return) begin
            ins = ctl_q.code[CODE_W-1:0];
        end else begin
            ins = store_out;
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (hit) begin
            ctl_d.pending = 1'b0;
            ctl_d.ready   = 1'b1;
            if (is_return || (ctl_q.cur_col == COL_W'(COLS - 1))) begin
                ctl_d.cur_col = '0;
                ctl_d.cur_row = (ctl_q.cur_row == ROW_W'(ROWS - 1)) ? '0
                              : ctl_q.cur_row + ROW_W'(1);
            end else begin
                ctl_d.cur_col = ctl_q.cur_col + COL_W'(1);
            end
        end
        if (host_strobe && ctl_q.ready) begin
            ctl_d.pending = 1'b1;
            ctl_d.code    = host_char;
            ctl_d.ready   = 1'b0;
        end
        if (frame_end) begin
            ctl_d.clr_run  = ctl_q.clr_pend || clear_req;
            ctl_d.clr_pend = 1'b0;
        end else if (clear_req) begin
            ctl_d.clr_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= '0;
            ctl_q.ready <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_ready  = ctl_q.ready;
    assign cell_active = active;
    assign scan_line   = line;
    assign glyph_addr  = !active ? '0 : (line == '0) ? ins : row_out;

endmodule

// File: rtl/textscreen_chk.sv
module textscreen_chk
    import textscreen_pkg::*;
#(
    parameter int COLS  = 40,
    parameter int LINES = 8,
    parameter int ROWS  = 24,
    parameter int DEPTH = 1024
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         host_strobe,
    input logic                         host_ready,
    input logic                         cell_active,
    input logic [safe_clog2(LINES)-1:0] scan_line,
    input logic                         hit,
    input logic [HOST_W-1:0]            held_code,
    input logic [safe_clog2(DEPTH)-1:0] cur_slot,
    input logic                         clr_run,
    input logic [safe_clog2(DEPTH)-1:0] slot,
    input logic [safe_clog2(ROWS)-1:0]  row,
    input logic [safe_clog2(COLS)-1:0]  col
);
    localparam int LINE_W = safe_clog2(LINES);
    localparam int SLOT_W = safe_clog2(DEPTH);

    // R3
    strobe_take_chk: assert property (@(posedge clk) disable iff (rst)
        host_strobe && host_ready |=> !host_ready);

    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        host_strobe && !host_ready |=> $stable(held_code));

    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ready) |-> $past(hit));

    // R5
    ready_after_insert_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> host_ready);

    // R2
    row_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cell_active) |-> $past(scan_line) == LINE_W'(LINES - 1));

    // R6
    cursor_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cur_slot) < ROWS * COLS);

    // R9
    clear_blocks_insert_chk: assert property (@(posedge clk) disable iff (rst)
        clr_run |-> !hit);

    // R4
    slot_align_chk: assert property (@(posedge clk) disable iff (rst)
        cell_active && (scan_line == '0) |-> slot == SLOT_W'(int'(row) * COLS + int'(col)));

endmodule

bind textscreen_store textscreen_chk #(
    .COLS (COLS),
    .LINES(LINES),
    .ROWS (ROWS),
    .DEPTH(DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_strobe(host_strobe),
    .host_ready (host_ready),
    .cell_active(cell_active),
    .scan_line  (scan_line),
    .hit        (hit),
    .held_code  (held_code),
    .cur_slot   (cur_slot),
    .clr_run    (clr_run),
    .slot       (slot),
    .row        (row),
    .col        (col)
);

// File: tb/test_textscreen_store.sv
`timescale 1ns/1ps
module test_textscreen_store;
    localparam int COLS  = 8;
    localparam int LINES = 8;
    localparam int ROWS  = 4;
    localparam int DEPTH = 48;
    localparam int CELLS = ROWS * COLS;
    localparam int ACT   = ROWS * LINES * COLS;
    localparam int FRAME = ACT + DEPTH - CELLS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] host_char = '0;
    logic       host_strobe = 1'b0;
    logic       clear_req = 1'b0;
    logic       host_ready, cell_active;
    logic [2:0] scan_line;
    logic [5:0] glyph_addr;

    always #2 clk = ~clk;

    textscreen_store #(
        .COLS(COLS), .LINES(LINES), .ROWS(ROWS), .DEPTH(DEPTH)
    ) i_textscreen_store (
        .clk(clk), .rst(rst), .host_char(host_char), .host_strobe(host_strobe),
        .host_ready(host_ready), .clear_req(clear_req), .cell_active(cell_active),
        .scan_line(scan_line), .glyph_addr(glyph_addr)
    );

    int checks = 0;
    int errors = 0;

    int t, cursor, pending, code, ready, clr_pend, clr_run;
    int store [DEPTH];
    int rowbuf [COLS];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at t=%0d", req, act, exp, t);
        end
    endtask

    // At entry: at a negedge with the model matching the design state.
    task automatic step(input bit strobe, input int ch, input bit clr, input string req);
        int row, line, col, slot, ins, exp_glyph, ready_pre;
        bit act, shift, hit;
        act  = (t < ACT);
        row  = t / (LINES * COLS);
        line = act ? (t / COLS) % LINES : 0;
        col  = t % COLS;
        slot = act ? row * COLS + col : CELLS + (t - ACT);
        shift = !act || (line == 0);
        hit  = shift && !clr_run && pending && (slot == cursor);
        if (clr_run) ins = 32;
        else if (hit && code != 13) ins = code & 63;
        else ins = store[slot];
        exp_glyph = !act ? 0 : (line == 0) ? ins : rowbuf[col];

        chk(cell_active == act, "R2 cell_active", int'(cell_active), int'(act));
        chk(int'(scan_line) == line, "R8 scan_line", int'(scan_line), line);
        chk(int'(host_ready) == ready, "R5 host_ready", int'(host_ready), ready);
        if (exp_glyph >= 0)
            chk(int'(glyph_addr) == exp_glyph, {req, " glyph"}, int'(glyph_addr), exp_glyph);

        host_strobe = strobe;
        host_char   = 7'(ch);
        clear_req   = clr;

        ready_pre = ready;
        if (shift) store[slot] = ins;
        if (act && line == 0) rowbuf[col] = ins;
        if (hit) begin
            pending = 0;
            ready = 1;
            if (code == 13) cursor = ((cursor / COLS + 1) * COLS) % CELLS;
            else cursor = (cursor + 1) % CELLS;
        end
        if (strobe && ready_pre == 1) begin
            pending = 1;
            code = ch;
            ready = 0;
        end
        if (t == FRAME - 1) begin
            clr_run = (clr_pend != 0 || clr) ? 1 : 0;
            clr_pend = 0;
        end else if (clr) begin
            clr_pend = 1;
        end
        t = (t + 1) % FRAME;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, req);
    endtask

    // Wait for ready, send, then poke a strobe that must be ignored (R3).
    task automatic send(input int ch, input string req);
        while (ready == 0) step(1'b0, 0, 1'b0, req);
        step(1'b1, ch, 1'b0, req);
        step(1'b1, 7'h55, 1'b0, "R3");
    endtask

    initial begin
        t = 0; cursor = 0; pending = 0; code = 0; ready = 1; clr_pend = 0; clr_run = 0;
        for (int i = 0; i < DEPTH; i++) store[i] = -1;
        for (int i = 0; i < COLS; i++) rowbuf[i] = -1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_ready == 1'b1, "R1 ready", int'(host_ready), 1);
        chk(cell_active == 1'b1, "R1 active", int'(cell_active), 1);
        chk(scan_line == 3'd0, "R1 line", int'(scan_line), 0);
        rst = 1'b0;
        idle(FRAME + 5, "R10");
        step(1'b0, 0, 1'b1, "R9");
        idle(2 * FRAME, "R9");
        send(7'h41, "R4");
        send(7'h42, "R4");
        send(7'h4D, "R7");
        send(7'h0D, "R7");
        send(7'h43, "R4");
        idle(FRAME, "R8");
        for (int i = 0; i < 25; i++) send(7'h30 + i, "R6");
        send(7'h5A, "R6");
        for (int i = 0; i < ROWS + 1; i++) send(7'h0D, "R7");
        send(7'h44, "R7");
        idle(FRAME, "R10");
        while (ready == 0) step(1'b0, 0, 1'b0, "R9");
        step(1'b1, 7'h45, 1'b1, "R9");
        idle(2 * FRAME, "R9");
        send(7'h46, "R4");
        idle(2 * FRAME, "R10");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule